// File: doc/BRIEF.md
# 1-Wire Bus Slot Monitor

This block listens to a single open-drain 1-Wire line without driving it. A free-running sample clock, gated by a per-sample enable, clocks it. The monitor times every low pulse in sample counts. A pulse whose line is high again at the end of the slot window is a data slot. The level at a fixed offset after the falling edge gives that slot's bit value. A pulse that is still low at the end of the slot window is measured to its rising edge. If the low time is long enough, it is a bus reset, and the monitor then samples the presence response and reports it once the reset slot has ended.

The monitor follows the two bus speeds. After a long (normal-speed) reset, it collects the first eight bits least significant bit first as a command byte. When that byte is one of the two overdrive-entry commands, the monitor switches all of its slot timing to the overdrive set. A later long reset switches it back. Every timing threshold is a parameter counted in enabled samples. Each event leaves the block as a one-clock strobe from a register.

Top module: `owire_slot_monitor`

## Requirements
- R1: After the synchronous reset `rst`, all strobes are low, the block uses normal timing, and no command byte is being collected.
- R2: The level at sample `N_SMP` after a falling edge is the bit value. If the line is high at sample `N_SLOT`, `bit_stb` pulses for one clock with `bit_val` set to that value.
- R3: In normal mode, a pulse that is still low at `N_SLOT` but rises at or before `N_RST` samples after the fall produces no event.
- R4: A low time above `N_RST` samples is a long reset. The level at `N_PRES` samples after the rise is the presence sample. If the line is high at `N_RSLOT` after the rise, `rst_stb` pulses with `present` equal to the inverse of that sample (1 = a device pulled low).
- R5: If the line is low at the reset-slot end, `rst_stb` is not raised, and the monitor waits for the next rising edge and measures it again.
- R6: Only the first eight bits after a long reset form the command byte, with the first bit in position 0. If that byte is 0x3C or 0x69, `od_enter_stb` pulses in the same clock as the eighth `bit_stb` and overdrive timing begins. Bits received before any bus reset never form a command.
- R7: In overdrive, data slots use `O_SMP` and `O_SLOT`, and reset slots use `O_PRES` and `O_RSLOT`.
- R8: In overdrive, a low time above `O_RST` (and not above `N_RST`) is a short reset. It is reported with overdrive timing and leaves the mode unchanged. A long reset leaves overdrive and pulses `od_exit_stb` only if overdrive was active.
- R9: The sample counter saturates at its all-ones value, so a low time longer than the counter range is still a long reset.
- R10: Only clocks with `smp_en` high count as samples, so the same waveform at half rate decodes the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample enable, one per sample instant |
| line_in | input | 1 | Raw 1-Wire line level |
| bit_stb | output | 1 | One-clock pulse for a completed data slot |
| bit_val | output | 1 | Value of the slot reported by `bit_stb` |
| rst_stb | output | 1 | One-clock pulse for a completed reset/presence slot |
| present | output | 1 | 1 when a device answered the reset, valid with `rst_stb` |
| od_enter_stb | output | 1 | One-clock pulse when overdrive timing starts |
| od_exit_stb | output | 1 | One-clock pulse when a long reset ends overdrive |

## Verification
A wrong speed mode shows at the ports within one slot. Overdrive-length bits decoded with normal offsets come out as wrong values or disappear, and normal bits decoded with overdrive offsets flip. A corrupted command register or bit index shows up as a missing or spurious `od_enter_stb` on the eighth bit after a reset. A counter that wraps, or a wrong reset threshold, shows up at the next rising edge as a missing or extra `rst_stb` once the reset slot has ended. The stimulus mixes random bytes, random presence answers and random choices between short and long resets with directed entry commands, a failed reset end, a counter overrun and half-rate sampling.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // line high, waiting for a low
    ST_DSAMP,  // waiting for the data sample point
    ST_DEND,   // waiting for the slot end check
    ST_RISE,   // long low, waiting for the line to rise
    ST_PRES,   // waiting for the presence sample point
    ST_REND    // waiting for the reset slot end check
  } mon_state_t;

  localparam logic [7:0] CMD_OD_A = 8'h3C;
  localparam logic [7:0] CMD_OD_B = 8'h69;
endpackage

// File: rtl/owm_line_sync.sv
module owm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_q
);
  logic [STAGES-1:0] chain;

  // the bus idles high, so every stage resets to 1
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], line_in};
  end

  assign line_q = chain[STAGES-1];
endmodule

// File: rtl/owm_sat_counter.sv
module owm_sat_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         load,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (load)                   cnt <= W'(1);
    else if (en && cnt != CNT_MAX)   cnt <= cnt + W'(1);
  end

  // R9
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load && cnt == CNT_MAX) |=> cnt == CNT_MAX);

  // R2
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == W'(1));
endmodule

// File: rtl/owm_cmd_tracker.sv
module owm_cmd_tracker
  import owm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_evt,
  input  logic bit_v,
  input  logic long_rst,
  output logic od,
  output logic enter
);
  logic [6:0] cmd_q;
  logic [3:0] idx;     // 8 means no byte is being collected
  logic [7:0] full_byte;

  assign full_byte = {bit_v, cmd_q};
  assign enter = bit_evt && (idx == 4'd7) &&
                 ((full_byte == CMD_OD_A) || (full_byte == CMD_OD_B));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      idx   <= 4'd8;
      od    <= 1'b0;
    end else if (long_rst) begin
      cmd_q <= '0;
      idx   <= 4'd0;
      od    <= 1'b0;
    end else if (bit_evt && idx < 4'd8) begin
      if (idx < 4'd7) cmd_q[idx[2:0]] <= bit_v;
      idx <= idx + 4'd1;
      if (enter) od <= 1'b1;
    end
  end

  // R6
  enter_sets_od_chk: assert property (@(posedge clk) disable iff (rst)
    enter |=> od);

  // R8
  long_rst_clears_od_chk: assert property (@(posedge clk) disable iff (rst)
    long_rst |=> !od);
endmodule

// File: rtl/owire_slot_monitor.sv
module owire_slot_monitor
  import owm_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int N_SMP   = 15,
  parameter int N_SLOT  = 60,
  parameter int N_RST   = 480,
  parameter int N_PRES  = 70,
  parameter int N_RSLOT = 400,
  parameter int O_SMP   = 2,
  parameter int O_SLOT  = 8,
  parameter int O_RST   = 48,
  parameter int O_PRES  = 9,
  parameter int O_RSLOT = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_en,
  input  logic line_in,
  output logic bit_stb,
  output logic bit_val,
  output logic rst_stb,
  output logic present,
  output logic od_enter_stb,
  output logic od_exit_stb
);
  localparam logic [CNT_W-1:0] TN_SMP   = CNT_W'(N_SMP);
  localparam logic [CNT_W-1:0] TN_SLOT  = CNT_W'(N_SLOT);
  localparam logic [CNT_W-1:0] TN_RST   = CNT_W'(N_RST);
  localparam logic [CNT_W-1:0] TN_PRES  = CNT_W'(N_PRES);
  localparam logic [CNT_W-1:0] TN_RSLOT = CNT_W'(N_RSLOT);
  localparam logic [CNT_W-1:0] TO_SMP   = CNT_W'(O_SMP);
  localparam logic [CNT_W-1:0] TO_SLOT  = CNT_W'(O_SLOT);
  localparam logic [CNT_W-1:0] TO_RST   = CNT_W'(O_RST);
  localparam logic [CNT_W-1:0] TO_PRES  = CNT_W'(O_PRES);
  localparam logic [CNT_W-1:0] TO_RSLOT = CNT_W'(O_RSLOT);

  mon_state_t       state;
  logic             lvl;
  logic [CNT_W-1:0] cnt;
  logic             od, enter;
  logic             dbit, psmp;
  logic             cnt_load, cnt_en;
  logic             long_hit, rst_hit, bit_evt, long_rst;
  logic [CNT_W-1:0] t_smp, t_slot, t_pres, t_rslot;

  owm_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .line_in(line_in), .line_q(lvl)
  );

  owm_sat_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .load(cnt_load), .cnt(cnt)
  );

  owm_cmd_tracker u_cmd (
    .clk(clk), .rst(rst), .bit_evt(bit_evt), .bit_v(dbit),
    .long_rst(long_rst), .od(od), .enter(enter)
  );

  // speed-dependent check points
  always_comb begin
    t_smp   = od ? TO_SMP   : TN_SMP;
    t_slot  = od ? TO_SLOT  : TN_SLOT;
    t_pres  = od ? TO_PRES  : TN_PRES;
    t_rslot = od ? TO_RSLOT : TN_RSLOT;
  end

  assign long_hit = cnt > TN_RST;
  assign rst_hit  = long_hit || (od && cnt > TO_RST);
  assign cnt_en   = smp_en && (state != ST_IDLE);
  assign cnt_load = smp_en && (((state == ST_IDLE) && !lvl) ||
                               ((state == ST_RISE) && lvl && rst_hit));
  assign bit_evt  = smp_en && (state == ST_DEND) && (cnt == t_slot) && lvl;
  assign long_rst = smp_en && (state == ST_RISE) && lvl && long_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      bit_stb      <= 1'b0;
      bit_val      <= 1'b0;
      rst_stb      <= 1'b0;
      present      <= 1'b0;
      od_enter_stb <= 1'b0;
      od_exit_stb  <= 1'b0;
      dbit         <= 1'b0;
      psmp         <= 1'b1;
    end else begin
      bit_stb      <= 1'b0;
      rst_stb      <= 1'b0;
      od_enter_stb <= 1'b0;
      od_exit_stb  <= 1'b0;
      if (smp_en) begin
        unique case (state)
          ST_IDLE:  if (!lvl) state <= ST_DSAMP;
          ST_DSAMP: if (cnt == t_smp) begin
                      dbit  <= lvl;
                      state <= ST_DEND;
                    end
          ST_DEND:  if (cnt == t_slot) begin
                      if (lvl) begin
                        bit_stb      <= 1'b1;
                        bit_val      <= dbit;
                        od_enter_stb <= enter;
                        state        <= ST_IDLE;
                      end else begin
                        state <= ST_RISE;
                      end
                    end
          ST_RISE:  if (lvl) begin
                      if (rst_hit) begin
                        od_exit_stb <= long_hit && od;
                        state       <= ST_PRES;
                      end else begin
                        state <= ST_IDLE;
                      end
                    end
          ST_PRES:  if (cnt == t_pres) begin
                      psmp  <= lvl;
                      state <= ST_REND;
                    end
          ST_REND:  if (cnt == t_rslot) begin
                      if (lvl) begin
                        rst_stb <= 1'b1;
                        present <= !psmp;
                        state   <= ST_IDLE;
                      end else begin
                        state <= ST_RISE;
                      end
                    end
          default:  state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bit_stb, rst_stb}));

  // R6
  enter_with_bit_chk: assert property (@(posedge clk) disable iff (rst)
    od_enter_stb |-> bit_stb && od);

  // R8
  exit_only_from_od_chk: assert property (@(posedge clk) disable iff (rst)
    od_exit_stb |-> $past(od) && !od);

  // R4
  rst_after_slot_end_chk: assert property (@(posedge clk) disable iff (rst)
    rst_stb |-> $past(state) == ST_REND);

  // R10
  idle_sample_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(state));
endmodule

// File: tb/owire_slot_monitor_tb.sv
module owire_slot_monitor_tb;
  logic clk = 1'b0;
  logic rst, smp_en, line_in;
  logic bit_stb, bit_val, rst_stb, present, od_enter_stb, od_exit_stb;

  always #2 clk = ~clk;  // 250 MHz

  owire_slot_monitor u_dut (
    .clk(clk), .rst(rst), .smp_en(smp_en), .line_in(line_in),
    .bit_stb(bit_stb), .bit_val(bit_val), .rst_stb(rst_stb),
    .present(present), .od_enter_stb(od_enter_stb), .od_exit_stb(od_exit_stb)
  );

  int n_chk = 0, n_fail = 0;
  int n_bits = 0, n_rsts = 0, n_ent = 0, n_ext = 0;
  logic [7:0] got_byte = '0;
  logic last_pres = 1'b0;
  bit half_rate = 1'b0;
  bit exp_od = 1'b0, first_cmd = 1'b0;
  int e_ent = 0, e_ext = 0;

  // event recorder, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (bit_stb) begin n_bits++; got_byte = {bit_val, got_byte[7:1]}; end
      if (rst_stb) begin n_rsts++; last_pres = present; end
      if (od_enter_stb) n_ent++;
      if (od_exit_stb)  n_ext++;
    end
    smp_en <= half_rate ? ~smp_en : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic lv, input int n);
    @(negedge clk);
    line_in = lv;
    for (int k = 0; k < n;) begin
      @(posedge clk);
      if (smp_en) k++;
    end
  endtask

  function automatic bit is_od_cmd(input logic [7:0] b);
    return (b == 8'h3C) || (b == 8'h69);
  endfunction

  task automatic send_bit(input logic b);
    if (exp_od) begin
      if (b) begin hold(0, 1); hold(1, 9); end
      else   begin hold(0, 6); hold(1, 6); end
    end else begin
      if (b) begin hold(0, 5);  hold(1, 65); end
      else   begin hold(0, 50); hold(1, 20); end
    end
  endtask

  // R2 R6 R7: one byte, LSB first, with expected mode change
  task automatic send_byte(input logic [7:0] b, input string req);
    int nb0 = n_bits;
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    hold(1, 4);
    if (first_cmd && is_od_cmd(b)) begin exp_od = 1'b1; e_ent++; end
    first_cmd = 1'b0;
    chk(n_bits - nb0 == 8, req, n_bits - nb0, 8);
    chk(got_byte == b, req, got_byte, b);
    chk(n_ent == e_ent, "R6", n_ent, e_ent);
  endtask

  // R4 R8: reset of given low length with or without a device answer
  task automatic bus_reset(input int low_len, input bit pres, input string req);
    int nr0 = n_rsts;
    hold(0, low_len);
    if (low_len > 480) begin
      if (exp_od) e_ext++;
      exp_od = 1'b0;
      first_cmd = 1'b1;
    end
    if (exp_od) begin
      if (pres) begin hold(1, 3); hold(0, 10); hold(1, 50); end
      else hold(1, 63);
    end else begin
      if (pres) begin hold(1, 20); hold(0, 100); hold(1, 400); end
      else hold(1, 520);
    end
    hold(1, 4);
    chk(n_rsts - nr0 == 1, req, n_rsts - nr0, 1);
    chk(last_pres == pres, req, last_pres, pres);
    chk(n_ext == e_ext, "R8", n_ext, e_ext);
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int nb0, nr0;
    logic [7:0] b;
    void'($urandom(32'd4242));
    rst = 1'b1; smp_en = 1'b1; line_in = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1
    chk({bit_stb, rst_stb, od_enter_stb, od_exit_stb} == 4'b0, "R1",
        {bit_stb, rst_stb, od_enter_stb, od_exit_stb}, 0);
    rst = 1'b0;
    hold(1, 10);
    chk({bit_stb, rst_stb, od_enter_stb, od_exit_stb} == 4'b0, "R1", n_bits, 0);

    // R6: entry command before any bus reset must not switch mode
    send_byte(8'h3C, "R6");
    send_byte(8'hA5, "R2");

    bus_reset(500, 1'b1, "R4");
    bus_reset(500, 1'b0, "R4");

    // R3: long-ish low, below reset threshold
    nb0 = n_bits; nr0 = n_rsts;
    hold(0, 100); hold(1, 30);
    chk(n_bits == nb0 && n_rsts == nr0, "R3", n_bits - nb0 + n_rsts - nr0, 0);

    // R5: line still low at reset slot end
    nr0 = n_rsts;
    hold(0, 500); hold(1, 20); hold(0, 400); hold(1, 60);
    first_cmd = 1'b1;
    chk(n_rsts == nr0 && n_bits == nb0, "R5", n_rsts - nr0, 0);

    // R6 R7 R8: enter, short reset keeps mode, long reset leaves it
    bus_reset(500, 1'b1, "R4");
    send_byte(8'h69, "R6");
    chk(n_ent == 1, "R6", n_ent, 1);
    send_byte(8'h5A, "R7");
    bus_reset(60, 1'b1, "R8");
    send_byte(8'hC3, "R7");
    bus_reset(500, 1'b0, "R8");
    chk(n_ext == 1, "R8", n_ext, 1);
    send_byte(8'h81, "R2");

    // R9: low beyond counter range
    bus_reset(4200, 1'b1, "R9");

    // random mix
    for (int it = 0; it < 10; it++) begin
      int sel = int'($urandom_range(0, 3));
      b = (sel == 0) ? 8'h3C : (sel == 1) ? 8'h69 : 8'($urandom());
      bus_reset(500, 1'($urandom_range(0, 1)), "R4");
      send_byte(b, "R6");
      for (int j = 0; j < 2; j++) send_byte(8'($urandom()), exp_od ? "R7" : "R2");
      if (exp_od && $urandom_range(0, 1) == 1)
        bus_reset(60, 1'($urandom_range(0, 1)), "R8");
      send_byte(8'($urandom()), exp_od ? "R7" : "R2");
    end

    // R10: half-rate sampling
    half_rate = 1'b1;
    bus_reset(500, 1'b1, "R10");
    send_byte(8'h3C, "R10");
    send_byte(8'h96, "R10");
    bus_reset(500, 1'b0, "R10");
    send_byte(8'h17, "R10");
    half_rate = 1'b0;

    hold(1, 10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule